// File: doc/BRIEF.md
# Dual-Mode Infrared Event Interrupt Controller

This block collects single-cycle event pulses from an infrared link controller and merges them into one level-sensitive interrupt line. It keeps two event groups: one for the slow asynchronous link mode and one for the medium and fast framed link modes. Each group has a sticky source register, a per-event mask register and a write-one-to-clear register. A transfer-mode register holds the 2-bit link mode select and three group-level masks that sit above the per-event masks.

The link controller drives a single 5-bit event vector. The current mode decides which group records it, so the two shared positions (bits 9 and 8) mean receive timeout and framing error in the slow group, and abort detected and CRC error in the framed group. Software reads and writes the registers through a 16-bit port with a word address. It opens the group that matches the current mode, services the events by reading the source, and clears them by writing ones.

Top module: `irx_irq_ctrl`

## Requirements
- R1: After reset the mode register reads 0x0111. Both per-event mask registers read 0x8B80. Both source registers read 0x0000 and irq_o is 0.
- R2: Event input evt_in[4] (frame receive end) sets source bit 15, evt_in[3] (transfer area overflow) sets bit 11, evt_in[2] sets bit 9, evt_in[1] sets bit 8, and evt_in[0] (frame transmit end) sets bit 7. In the slow group bit 9 is receive timeout and bit 8 is framing error. In the framed group bit 9 is abort detected and bit 8 is CRC error.
- R3: The mode field is bits 15:14 of the mode register: 00 slow, 11 medium, 10 fast, 01 reserved. Events are recorded in the slow group in mode 00, in the framed group in modes 10 and 11, and dropped in mode 01. A source bit is set at the clock edge where its pulse is sampled.
- R4: In a clear register, writing 1 to a bit clears the matching source bit. Writing 0 leaves that bit unchanged. The clear registers read 0x0000.
- R5: When an event pulse and a clear write hit the same source bit in the same cycle, the bit ends up set.
- R6: A set bit in a per-event mask register keeps that source bit from raising irq_o. The source bit is still recorded.
- R7: In the mode register, bit 0 masks the slow group, bit 4 masks the framed group and bit 8 masks the receive-FIFO request input. A set bit blocks that whole group.
- R8: irq_o is the OR of three terms. Each group contributes when its group mask is clear and it has any source bit whose event mask is clear. The FIFO request contributes when bit 8 is clear. irq_o follows register state combinationally.
- R9: Writes to the source registers are ignored. Register bits with no function read 0 and ignore writes.
- R10: Word addresses: 0 mode, 1 slow source, 2 slow mask, 3 slow clear, 4 framed source, 5 framed mask, 6 framed clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 5 | One-cycle event pulses from the link controller |
| fifo_rx_req | input | 1 | Level request from the receive FIFO |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The bench sends each event into every mode. A design that steered by only one mode bit would fill the wrong group in fast mode or record events in the reserved mode. It also pulses an event in the same cycle as a clear write of the same bit; a design that let the clear win would lose that event. It checks that a source bit blocked by its event mask stays recorded but keeps irq_o low, and that writing zero to a clear register changes nothing. It also checks that the FIFO request is gated only by bit 8, so a swapped mask position shows up as a wrong interrupt.

// File: rtl/irx_irq_pkg.sv
package irx_irq_pkg;
   localparam int unsigned EVT_N   = 5;
   localparam int unsigned REG_W   = 16;
   // source bit position for each event input index (0 = transmit end)
   localparam int unsigned EVT_POS [EVT_N] = '{7, 8, 9, 11, 15};

   localparam int unsigned GM_SLOW_POS = 0;
   localparam int unsigned GM_FR_POS   = 4;
   localparam int unsigned GM_FIFO_POS = 8;
   localparam int unsigned MODE_LO_POS = 14;

   localparam int unsigned A_MODE   = 0;
   localparam int unsigned A_SA_SRC = 1;
   localparam int unsigned A_SA_MSK = 2;
   localparam int unsigned A_SA_CLR = 3;
   localparam int unsigned A_FR_SRC = 4;
   localparam int unsigned A_FR_MSK = 5;
   localparam int unsigned A_FR_CLR = 6;

   typedef enum logic [1:0] {
      LM_SLOW = 2'b00,
      LM_RSVD = 2'b01,
      LM_FAST = 2'b10,
      LM_MED  = 2'b11
   } link_mode_e;

   typedef struct packed {
      logic fifo;
      logic fr;
      logic slow;
   } grp_mask_t;
endpackage

// File: rtl/irx_evt_group.sv
module irx_evt_group
   import irx_irq_pkg::*;
#(
   parameter int unsigned DATA_W = REG_W,
   parameter int unsigned NEVT   = EVT_N
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NEVT-1:0]   evt_i,
   input  logic              msk_we,
   input  logic              clr_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [NEVT-1:0]   src_o,
   output logic [NEVT-1:0]   msk_o,
   output logic [DATA_W-1:0] src_word_o,
   output logic [DATA_W-1:0] msk_word_o,
   output logic              pend_o
);
   logic [NEVT-1:0] src_q;
   logic [NEVT-1:0] msk_q;
   logic            unused_wbits;

   assign unused_wbits = ^wdata;

   for (genvar k = 0; k < NEVT; k++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            src_q[k] <= 1'b0;
         else if (evt_i[k])
            src_q[k] <= 1'b1;
         else if (clr_we && wdata[EVT_POS[k]])
            src_q[k] <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            msk_q[k] <= 1'b1;
         else if (msk_we)
            msk_q[k] <= wdata[EVT_POS[k]];
      end
   end

   always_comb begin
      src_word_o = '0;
      msk_word_o = '0;
      for (int k = 0; k < int'(NEVT); k++) begin
         src_word_o[EVT_POS[k]] = src_q[k];
         msk_word_o[EVT_POS[k]] = msk_q[k];
      end
   end

   assign src_o  = src_q;
   assign msk_o  = msk_q;
   assign pend_o = |(src_q & ~msk_q);
endmodule

// File: rtl/irx_mode_reg.sv
module irx_mode_reg
   import irx_irq_pkg::*;
#(
   parameter int unsigned DATA_W = REG_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output link_mode_e        mode_o,
   output grp_mask_t         gmask_o,
   output logic [DATA_W-1:0] word_o
);
   link_mode_e mode_q;
   grp_mask_t  gm_q;
   logic       unused_wbits;

   assign unused_wbits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= LM_SLOW;
         gm_q   <= '{fifo: 1'b1, fr: 1'b1, slow: 1'b1};
      end else if (we) begin
         mode_q  <= link_mode_e'(wdata[MODE_LO_POS +: 2]);
         gm_q.slow <= wdata[GM_SLOW_POS];
         gm_q.fr   <= wdata[GM_FR_POS];
         gm_q.fifo <= wdata[GM_FIFO_POS];
      end
   end

   always_comb begin
      word_o = '0;
      word_o[MODE_LO_POS +: 2] = mode_q;
      word_o[GM_SLOW_POS]      = gm_q.slow;
      word_o[GM_FR_POS]        = gm_q.fr;
      word_o[GM_FIFO_POS]      = gm_q.fifo;
   end

   assign mode_o  = mode_q;
   assign gmask_o = gm_q;
endmodule

// File: rtl/irx_evt_steer.sv
module irx_evt_steer
   import irx_irq_pkg::*;
#(
   parameter int unsigned NEVT = EVT_N
)(
   input  link_mode_e      mode_i,
   input  logic [NEVT-1:0] evt_i,
   output logic [NEVT-1:0] slow_o,
   output logic [NEVT-1:0] fr_o
);
   always_comb begin
      slow_o = '0;
      fr_o   = '0;
      unique case (mode_i)
         LM_SLOW:         slow_o = evt_i;
         LM_FAST, LM_MED: fr_o   = evt_i;
         default:         ;
      endcase
   end
endmodule

// File: rtl/irx_irq_ctrl.sv
module irx_irq_ctrl
   import irx_irq_pkg::*;
#(
   parameter int unsigned DATA_W = REG_W,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned NEVT   = EVT_N
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NEVT-1:0]   evt_in,
   input  logic              fifo_rx_req,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o
);
   localparam int unsigned NREG = A_FR_CLR + 1;

   if (DATA_W < 16) begin : g_bad_width
      $error("irx_irq_ctrl: DATA_W must be at least 16");
   end
   if ((1 << ADDR_W) < NREG) begin : g_bad_addr
      $error("irx_irq_ctrl: ADDR_W too narrow for register map");
   end
   if (NEVT != EVT_N) begin : g_bad_evt
      $error("irx_irq_ctrl: NEVT must match event layout");
   end

   link_mode_e        mode_q;
   grp_mask_t         gmask;
   logic [DATA_W-1:0] mode_word;
   logic [NEVT-1:0]   evt_sa, evt_fr;
   logic [NEVT-1:0]   sa_src, sa_msk, fr_src, fr_msk;
   logic [DATA_W-1:0] sa_src_w, sa_msk_w, fr_src_w, fr_msk_w;
   logic              sa_pend, fr_pend;
   logic              mode_we, sa_msk_we, sa_clr_we, fr_msk_we, fr_clr_we;

   assign mode_we   = reg_we && (reg_addr == ADDR_W'(A_MODE));
   assign sa_msk_we = reg_we && (reg_addr == ADDR_W'(A_SA_MSK));
   assign sa_clr_we = reg_we && (reg_addr == ADDR_W'(A_SA_CLR));
   assign fr_msk_we = reg_we && (reg_addr == ADDR_W'(A_FR_MSK));
   assign fr_clr_we = reg_we && (reg_addr == ADDR_W'(A_FR_CLR));

   irx_mode_reg #(.DATA_W(DATA_W)) mode_i (
      .clk(clk), .rst_n(rst_n), .we(mode_we), .wdata(reg_wdata),
      .mode_o(mode_q), .gmask_o(gmask), .word_o(mode_word)
   );

   irx_evt_steer #(.NEVT(NEVT)) steer_i (
      .mode_i(mode_q), .evt_i(evt_in), .slow_o(evt_sa), .fr_o(evt_fr)
   );

   irx_evt_group #(.DATA_W(DATA_W), .NEVT(NEVT)) sa_grp_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_sa),
      .msk_we(sa_msk_we), .clr_we(sa_clr_we), .wdata(reg_wdata),
      .src_o(sa_src), .msk_o(sa_msk), .src_word_o(sa_src_w),
      .msk_word_o(sa_msk_w), .pend_o(sa_pend)
   );

   irx_evt_group #(.DATA_W(DATA_W), .NEVT(NEVT)) fr_grp_i (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_fr),
      .msk_we(fr_msk_we), .clr_we(fr_clr_we), .wdata(reg_wdata),
      .src_o(fr_src), .msk_o(fr_msk), .src_word_o(fr_src_w),
      .msk_word_o(fr_msk_w), .pend_o(fr_pend)
   );

   always_comb begin
      case (reg_addr)
         ADDR_W'(A_MODE):   reg_rdata = mode_word;
         ADDR_W'(A_SA_SRC): reg_rdata = sa_src_w;
         ADDR_W'(A_SA_MSK): reg_rdata = sa_msk_w;
         ADDR_W'(A_FR_SRC): reg_rdata = fr_src_w;
         ADDR_W'(A_FR_MSK): reg_rdata = fr_msk_w;
         default:           reg_rdata = '0;
      endcase
   end

   assign irq_o = (sa_pend && !gmask.slow) ||
                  (fr_pend && !gmask.fr)   ||
                  (fifo_rx_req && !gmask.fifo);
endmodule

// File: rtl/irx_irq_chk.sv
module irx_irq_chk
   import irx_irq_pkg::*;
#(
   parameter int unsigned DATA_W = REG_W,
   parameter int unsigned NEVT   = EVT_N
)(
   input logic              clk,
   input logic              rst_n,
   input logic [NEVT-1:0]   evt_in,
   input logic [1:0]        mode_q,
   input logic [2:0]        gmask,
   input logic [NEVT-1:0]   sa_src,
   input logic [NEVT-1:0]   fr_src,
   input logic              sa_clr_we,
   input logic [DATA_W-1:0] wdata,
   input logic              fifo_rx_req,
   input logic              irq_o
);
   logic [NEVT-1:0] wclr;
   logic            unused_wbits;

   assign unused_wbits = ^wdata;

   always_comb begin
      for (int k = 0; k < int'(NEVT); k++) wclr[k] = wdata[EVT_POS[k]];
   end

   AST_SLOW_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b00 && evt_in != '0) |=> ((sa_src & $past(evt_in)) == $past(evt_in))); // R5

   AST_FR_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[1] && evt_in != '0) |=> ((fr_src & $past(evt_in)) == $past(evt_in))); // R3

   AST_RSVD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b01 && !sa_clr_we) |=> $stable(sa_src)); // R3

   AST_CLR_ONES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (sa_clr_we && !(mode_q == 2'b00 && evt_in != '0))
      |=> (sa_src == ($past(sa_src) & ~$past(wclr)))); // R4

   AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (sa_src != '0 || fr_src != '0 || fifo_rx_req)); // R8

   AST_GROUPS_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (gmask == 3'b111) |-> !irq_o); // R7
endmodule

bind irx_irq_ctrl irx_irq_chk #(.DATA_W(DATA_W), .NEVT(NEVT)) chk_i (
   .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .mode_q(mode_q),
   .gmask(gmask), .sa_src(sa_src), .fr_src(fr_src),
   .sa_clr_we(sa_clr_we), .wdata(reg_wdata),
   .fifo_rx_req(fifo_rx_req), .irq_o(irq_o)
);

// File: tb/irx_irq_ctrl_tb_top.sv
module irx_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  evt_in = '0;
   logic        fifo_rx_req = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq_o;
   int          n_chk = 0;
   int          n_err = 0;

   always #5 clk = ~clk;

   irx_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .fifo_rx_req(fifo_rx_req),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [2:0] a, logic [15:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1 check(req, reg_rdata, exp);
   endtask

   task automatic irq_chk(string req, logic exp);
      @(negedge clk);
      #1 check(req, {15'd0, irq_o}, {15'd0, exp});
   endtask

   task automatic pulse(logic [4:0] ev);
      @(negedge clk);
      evt_in = ev;
      @(negedge clk);
      evt_in = '0;
   endtask

   task automatic t_reset;
      rd_chk("R1 mode", 3'd0, 16'h0111);
      rd_chk("R1 slow mask", 3'd2, 16'h8B80);
      rd_chk("R1 framed mask", 3'd5, 16'h8B80);
      rd_chk("R1 slow src", 3'd1, 16'h0000);
      rd_chk("R1 framed src", 3'd4, 16'h0000);
      irq_chk("R1 irq", 1'b0);
   endtask

   task automatic t_layout;
      pulse(5'b11111);
      rd_chk("R2 slow src layout", 3'd1, 16'h8B80);
      rd_chk("R3 framed untouched in slow", 3'd4, 16'h0000);
      irq_chk("R7 groups masked", 1'b0);
   endtask

   task automatic t_masks;
      wr(3'd0, 16'h0110);
      irq_chk("R6 event masks block", 1'b0);
      wr(3'd2, 16'h0000);
      irq_chk("R8 irq from slow group", 1'b1);
      wr(3'd2, 16'h0080);
      wr(3'd3, 16'h8B00);
      rd_chk("R4 clear ones", 3'd1, 16'h0080);
      irq_chk("R6 masked bit kept silent", 1'b0);
      wr(3'd3, 16'h0000);
      rd_chk("R4 zero write no effect", 3'd1, 16'h0080);
      wr(3'd3, 16'h0080);
      rd_chk("R4 last bit cleared", 3'd1, 16'h0000);
      rd_chk("R4 clear reads zero", 3'd3, 16'h0000);
   endtask

   task automatic t_steer;
      wr(3'd0, 16'hC111);
      pulse(5'b00110);
      rd_chk("R3 medium to framed", 3'd4, 16'h0300);
      rd_chk("R3 medium not slow", 3'd1, 16'h0000);
      wr(3'd0, 16'h8111);
      pulse(5'b00001);
      rd_chk("R3 fast to framed", 3'd4, 16'h0380);
      wr(3'd0, 16'h4111);
      rd_chk("R3 mode readback", 3'd0, 16'h4111);
      pulse(5'b11111);
      rd_chk("R3 reserved drops slow", 3'd1, 16'h0000);
      rd_chk("R3 reserved drops framed", 3'd4, 16'h0380);
   endtask

   task automatic t_race;
      wr(3'd0, 16'h8111);
      @(negedge clk);
      evt_in = 5'b00100;
      reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 16'h0380;
      @(negedge clk);
      evt_in = '0; reg_we = 1'b0;
      rd_chk("R5 event beats clear", 3'd4, 16'h0200);
   endtask

   task automatic t_fifo;
      fifo_rx_req = 1'b1;
      irq_chk("R7 fifo masked", 1'b0);
      wr(3'd0, 16'h8011);
      irq_chk("R7 fifo bit8 open", 1'b1);
      wr(3'd0, 16'h8101);
      irq_chk("R6 framed masked per event", 1'b0);
      wr(3'd5, 16'h0000);
      irq_chk("R8 framed group irq", 1'b1);
      wr(3'd0, 16'h8111);
      fifo_rx_req = 1'b0;
      irq_chk("R7 all closed", 1'b0);
   endtask

   task automatic t_ignore;
      wr(3'd1, 16'hFFFF);
      rd_chk("R9 source write ignored", 3'd1, 16'h0000);
      wr(3'd4, 16'h0000);
      rd_chk("R9 framed source write ignored", 3'd4, 16'h0200);
      wr(3'd0, 16'hFFFF);
      rd_chk("R9 mode spare bits", 3'd0, 16'hC111);
      wr(3'd2, 16'hFFFF);
      rd_chk("R9 mask spare bits", 3'd2, 16'h8B80);
      rd_chk("R10 unmapped address", 3'd7, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_layout();
      t_masks();
      t_steer();
      t_race();
      t_fifo();
      t_ignore();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #1_000_000;
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule